// File: doc/BRIEF.md
# UART Interrupt Status and Routing

This block is the interrupt bookkeeping of a serial port. Datapath logic reports events (character received, receive timeout, modem line changes, line errors) as one-cycle set pulses on a status-wide input vector. The block latches them into a sticky raw status register. Software selects which of them may raise a line through an enable register and acknowledges them through a write-one-to-clear register. A write to the transmit data address raises the transmit event on its own.

Eleven status bits are grouped into five interrupt classes. Each class drives a dedicated level output, and a sixth output is asserted whenever any class is active. All outputs are combinational functions of the registered raw status and enable, so they follow any register change one cycle later.

The status layout is fixed, and the routing depends on it. Bits 3..0 hold the modem group, bit 4 receive, bit 5 transmit, bit 6 receive timeout, and bits 10..7 the error group. The register addresses are: 0 transmit data (write only), 1 enable, 2 raw status, 3 enabled status, 4 clear. Addresses 5 to 7 are unmapped.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable and raw status registers read 0 and all six interrupt outputs are low.
- R2: Reading address 3 returns the raw status ANDed bitwise with the enable register.
- R3: Writing address 4 clears each raw status bit whose write-data bit is 1 and leaves all other raw bits unchanged.
- R4: Reading address 4 always returns 0.
- R5: Writes to address 2 (raw) and address 3 (enabled status) change neither the raw status nor the enable register.
- R6: Each dedicated output is high exactly when its group has an enabled raw bit: irq_rx bit 4, irq_tx bit 5, irq_rt bit 6, irq_modem bits 3..0, irq_err bits 10..7.
- R7: irq_any is the OR of the five dedicated outputs.
- R8: A write to address 0 sets raw status bit 5 (transmit) on the next clock edge.
- R9: A set pulse on a bit in the same cycle as a clear of that bit leaves the bit set.
- R10: A raw bit set by a pulse on evt_set stays set until it is cleared through address 4.
- R11: Reads of addresses 5 to 7 return 0, and writes there change no register.
- R12: Outputs reflect a register change in the cycle following the clock edge that stored it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set | input | 11 | One-cycle set pulses per status bit |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for read and write |
| bus_wdata | input | 11 | Write data |
| bus_rdata | output | 11 | Combinational read data for bus_addr |
| irq_any | output | 1 | Combined interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rt | output | 1 | Receive-timeout interrupt |
| irq_modem | output | 1 | Modem-status interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The cycle-level properties are checked on every edge: set taking priority over clear, stickiness of raw bits, the clear effect, immunity to writes at the read-only and unmapped addresses, the transmit-data side effect, readback of enabled status and of the clear address, and the combined line covering the dedicated ones. The bench sweeps all 2048 raw patterns against derived enable patterns. This shows that each output is routed to the correct group under the fixed bit layout, which no local property can establish. Partial clears, the reset state and the one-cycle output latency are shown by directed scenarios.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int STATUS_W = 11;
    localparam int NUM_GRP  = 5;
    localparam int ADDR_W   = 3;

    // status bit layout (routing depends on it)
    localparam int BIT_RX = 4;
    localparam int BIT_TX = 5;
    localparam int BIT_RT = 6;

    // group indices
    localparam int GRP_RX    = 0;
    localparam int GRP_TX    = 1;
    localparam int GRP_RT    = 2;
    localparam int GRP_MODEM = 3;
    localparam int GRP_ERR   = 4;

    // register addresses
    localparam int ADR_TXDATA = 0;
    localparam int ADR_ENABLE = 1;
    localparam int ADR_RAW    = 2;
    localparam int ADR_MASKED = 3;
    localparam int ADR_CLEAR  = 4;

    typedef logic [STATUS_W-1:0] status_t;

    typedef struct packed {
        status_t enable;
        status_t raw;
    } irq_state_t;

    function automatic status_t group_mask(input int grp);
        status_t m;
        m = '0;
        case (grp)
            GRP_RX:    m[BIT_RX] = 1'b1;
            GRP_TX:    m[BIT_TX] = 1'b1;
            GRP_RT:    m[BIT_RT] = 1'b1;
            GRP_MODEM: m[3:0]    = 4'hF;
            GRP_ERR:   m[10:7]   = 4'hF;
            default:   m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uart_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  status_t evt_set,
    input  logic    wr_enable,
    input  logic    wr_clear,
    input  logic    wr_txdata,
    input  status_t wdata,
    output status_t enable_q,
    output status_t raw_q
);

    irq_state_t st_d;
    irq_state_t st_q;

    always_comb begin
        status_t set_v;
        status_t clr_v;
        st_d  = st_q;
        set_v = evt_set;
        if (wr_txdata) begin
            set_v[BIT_TX] = 1'b1;
        end
        clr_v = wr_clear ? wdata : '0;
        if (wr_enable) begin
            st_d.enable = wdata;
        end
        // set is applied after clear so a coincident event survives
        st_d.raw = (st_q.raw & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enable_q = st_q.enable;
    assign raw_q    = st_q.raw;

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((raw_q & $past(evt_set)) == $past(evt_set)));

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_clear |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

    a_r3_clear_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clear && evt_set == '0 && !wr_txdata) |=>
            ((raw_q & $past(wdata)) == '0 &&
             (raw_q & ~$past(wdata)) == ($past(raw_q) & ~$past(wdata))));

    a_r8_tx_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_txdata |=> raw_q[BIT_TX]);

    a_r5_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_enable |=> $stable(enable_q));

endmodule

// File: rtl/uart_irq_route.sv
module uart_irq_route
    import uart_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  status_t raw,
    input  status_t enable,
    output status_t masked,
    output logic [NUM_GRP-1:0] grp_irq,
    output logic    any_irq
);

    assign masked = raw & enable;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam status_t GMASK = group_mask(g);
        assign grp_irq[g] = |(masked & GMASK);
    end

    assign any_irq = |grp_irq;

    a_r7_combined: assert property (@(posedge clk) disable iff (!rst_n)
        any_irq == ((raw & enable) != '0));

    a_r6_none_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> (grp_irq == '0));

endmodule

// File: rtl/uart_irq_rdmux.sv
module uart_irq_rdmux
    import uart_irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  status_t enable,
    input  status_t raw,
    input  status_t masked,
    output status_t rdata
);

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(ADR_ENABLE): rdata = enable;
            ADDR_W'(ADR_RAW):    rdata = raw;
            ADDR_W'(ADR_MASKED): rdata = masked;
            default:             rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] evt_set,
    input  logic                bus_wr_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [STATUS_W-1:0] bus_wdata,
    output logic [STATUS_W-1:0] bus_rdata,
    output logic                irq_any,
    output logic                irq_rx,
    output logic                irq_tx,
    output logic                irq_rt,
    output logic                irq_modem,
    output logic                irq_err
);

    logic wr_enable_s;
    logic wr_clear_s;
    logic wr_txdata_s;
    status_t enable_q;
    status_t raw_q;
    status_t masked_s;
    logic [NUM_GRP-1:0] grp_s;

    assign wr_enable_s = bus_wr_en && (bus_addr == ADDR_W'(ADR_ENABLE));
    assign wr_clear_s  = bus_wr_en && (bus_addr == ADDR_W'(ADR_CLEAR));
    assign wr_txdata_s = bus_wr_en && (bus_addr == ADDR_W'(ADR_TXDATA));

    uart_irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_set   (evt_set),
        .wr_enable (wr_enable_s),
        .wr_clear  (wr_clear_s),
        .wr_txdata (wr_txdata_s),
        .wdata     (bus_wdata),
        .enable_q  (enable_q),
        .raw_q     (raw_q)
    );

    uart_irq_route u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (raw_q),
        .enable  (enable_q),
        .masked  (masked_s),
        .grp_irq (grp_s),
        .any_irq (irq_any)
    );

    uart_irq_rdmux u_rdmux (
        .addr   (bus_addr),
        .enable (enable_q),
        .raw    (raw_q),
        .masked (masked_s),
        .rdata  (bus_rdata)
    );

    assign irq_rx    = grp_s[GRP_RX];
    assign irq_tx    = grp_s[GRP_TX];
    assign irq_rt    = grp_s[GRP_RT];
    assign irq_modem = grp_s[GRP_MODEM];
    assign irq_err   = grp_s[GRP_ERR];

    a_r2_masked_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(ADR_MASKED)) |-> (bus_rdata == (raw_q & enable_q)));

    a_r4_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(ADR_CLEAR)) |-> (bus_rdata == '0));

    a_r5_readonly_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && (bus_addr == ADDR_W'(ADR_RAW) || bus_addr == ADDR_W'(ADR_MASKED))
         && evt_set == '0) |=> ($stable(raw_q) && $stable(enable_q)));

    a_r11_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr > ADDR_W'(ADR_CLEAR) && evt_set == '0)
            |=> ($stable(raw_q) && $stable(enable_q)));

endmodule

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] evt_set = '0;
    logic        bus_wr_en = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [10:0] bus_wdata = '0;
    logic [10:0] bus_rdata;
    logic irq_any, irq_rx, irq_tx, irq_rt, irq_modem, irq_err;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    uart_irq_ctrl u_uart_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set),
        .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_any(irq_any), .irq_rx(irq_rx),
        .irq_tx(irq_tx), .irq_rt(irq_rt), .irq_modem(irq_modem), .irq_err(irq_err)
    );

    task automatic chk(input string tag, input logic [10:0] got, input logic [10:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [10:0] d);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [10:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [10:0] v);
        evt_set = v;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic chk_irqs(input string tag, input logic [10:0] m);
        logic [4:0] e;
        e[0] = m[4];
        e[1] = m[5];
        e[2] = m[6];
        e[3] = |m[3:0];
        e[4] = |m[10:7];
        chk({tag, " R6 rx"},    11'(irq_rx),    11'(e[0]));
        chk({tag, " R6 tx"},    11'(irq_tx),    11'(e[1]));
        chk({tag, " R6 rt"},    11'(irq_rt),    11'(e[2]));
        chk({tag, " R6 modem"}, 11'(irq_modem), 11'(e[3]));
        chk({tag, " R6 err"},   11'(irq_err),   11'(e[4]));
        chk({tag, " R7 any"},   11'(irq_any),   11'(|e));
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [10:0] d;
        logic [10:0] m;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(3'd1, d); chk("R1 enable", d, '0);
        rd(3'd2, d); chk("R1 raw", d, '0);
        chk_irqs("R1", '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 transmit data write sets bit 5; R12 one-cycle latency
        wr(3'd1, 11'h7ff);
        bus_wr_en = 1'b1; bus_addr = 3'd0; bus_wdata = 11'h041;
        #1;
        chk("R12 before edge", 11'(irq_tx), 11'd0);
        @(negedge clk);
        bus_wr_en = 1'b0;
        chk("R12 after edge", 11'(irq_tx), 11'd1);
        rd(3'd2, d); chk("R8 tx bit", d, 11'h020);

        // R10 sticky across idle cycles
        pulse(11'h481);
        repeat (5) @(negedge clk);
        rd(3'd2, d); chk("R10 sticky", d, 11'h4a1);

        // R3 partial clear
        wr(3'd4, 11'h401);
        rd(3'd2, d); chk("R3 partial clear", d, 11'h0a0);
        // R4 clear reads zero
        rd(3'd4, d); chk("R4 clear read", d, '0);

        // R5 writes to raw/masked ignored
        wr(3'd2, 11'h7ff);
        wr(3'd3, 11'h000);
        rd(3'd2, d); chk("R5 raw kept", d, 11'h0a0);
        rd(3'd1, d); chk("R5 enable kept", d, 11'h7ff);

        // R11 unmapped
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 11'h000);
            rd(3'(a), d); chk("R11 unmapped read", d, '0);
        end
        rd(3'd2, d); chk("R11 raw kept", d, 11'h0a0);
        rd(3'd1, d); chk("R11 enable kept", d, 11'h7ff);

        // R9 set wins over coincident clear
        pulse(11'h7ff);
        evt_set = 11'h110;
        wr(3'd4, 11'h7ff);
        evt_set = '0;
        rd(3'd2, d); chk("R9 set wins", d, 11'h110);

        // sweep: every raw pattern against a derived enable pattern
        for (int v = 0; v < 2048; v++) begin
            m = 11'((v * 613 + 91) & 11'h7ff);
            wr(3'd4, 11'h7ff);
            wr(3'd1, m);
            pulse(11'(v));
            rd(3'd2, d); chk("R10 raw sweep", d, 11'(v));
            rd(3'd3, d); chk("R2 masked sweep", d, 11'(v) & m);
            chk_irqs("sweep", 11'(v) & m);
        end

        // enable off hides everything
        wr(3'd1, 11'h000);
        chk_irqs("R6 disabled", '0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule